// File: doc/BRIEF.md
# Partial Flag-Write Stall Detector

This block sits in an in-order issue stage beside the flag register. Every cycle it may receive one decoded instruction described by a valid bit, a mask of the condition flags it reads, a mask of the flags it writes and a class code. It remembers whether the most recent flag producer belongs to a class that only partly updates the flag register, and which arithmetic flags that producer touched. When a reader would have to merge flags coming from more than one producer, the instruction is held for a fixed penalty. It issues once the penalty has run out.

The decision comes from the class code. The raw write mask does not decide it. For example, a bit-test class is a partial producer even when it writes the same flags as a logical AND. Whole-register readers, which copy all flags to a register or push them, stall after any partial producer, including one that only touched the direction or interrupt flag. Single-flag readers consider only the arithmetic group. They stall when they need any arithmetic flag that the last partial producer left alone, and this includes readers that need nothing else.

Top module: `pfs_stall_top`

## Requirements
- R1: After reset `stall` and `iss_valid` are low, and the flag state counts as fully written, so the first reader issues without a stall.
- R2: An accepted instruction that does not stall appears on `iss_valid`/`iss_cls` in the next cycle with `iss_waited` low. `iss_cls` keeps its value in cycles with no issue.
- R3: After a partial-class producer that wrote at least one arithmetic flag (mask bits OF=7, SF=4, ZF=3, AF=2, PF=1, CF=0), a single-flag reader (`in_rd` non-zero, class not 26/27) stalls if it reads any arithmetic flag outside that producer's `in_wr`. This holds even when it reads only such flags.
- R4: A single-flag reader whose arithmetic reads all lie inside the last partial producer's arithmetic write mask does not stall.
- R5: A full-class producer (codes 17..25: and, or, xor, add, add-carry, sub, sub-borrow, compare, negate) clears all partial state.
- R6: A whole-flags reader (code 26 load-flags, 27 push-flags) stalls if any partial-class producer (codes 1..16: inc, dec, test, bit-test, bit-scan, clc, stc, cmc, cld, std, cli, sti, mul, imul, shift, rotate) has issued since the last full-class producer or stall release.
- R7: A partial-class producer that writes no arithmetic flag (only DF=bit 6 or IF=bit 5) leaves the single-flag reader state unchanged.
- R8: A stall keeps `stall` high for exactly 4 cycles. During those cycles all inputs are ignored and the tracking state is frozen.
- R9: A held instruction issues in the cycle in which `stall` falls, with `iss_waited` high. On release the partial state is cleared first, and then the held instruction's own write is applied.
- R10: When `in_valid` is low, nothing issues and the state is unchanged.
- R11: An instruction with `in_rd` zero and a class other than 26/27 never stalls. Classes 0 (no flags), 28 (branch) and 29 (set-on-condition) do not change the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decoded instruction present |
| in_cls | input | 5 | Instruction class code |
| in_rd | input | 8 | Flags read, bit order {OF,DF,IF,SF,ZF,AF,PF,CF} |
| in_wr | input | 8 | Flags written, same bit order |
| stall | output | 1 | Issue held, inputs ignored |
| iss_valid | output | 1 | An instruction issues this cycle |
| iss_cls | output | 5 | Class of the issuing instruction |
| iss_waited | output | 1 | The issuing instruction was held by a stall |

## Verification
The directed stimulus sends a partial increment followed by three branches: one reading carry and zero, one reading only carry, and one reading only zero. This shows that the rule looks at flags left untouched rather than at overlap. Shift–or–push and test/and pairs before whole-flag readers show that the class decides, not the write mask. Clear-direction and clear-carry ahead of a zero reader show that the direction flag stays outside the single-flag rule. Further sequences drive a partial producer during a stall, a writer that is itself held, and long random streams against a reference model, which expose a frozen state that leaks, an off-by-one penalty and a wrong release order.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    localparam int FLAG_W  = 8;
    localparam int CLS_W   = 5;

    localparam int FB_CF = 0;
    localparam int FB_PF = 1;
    localparam int FB_AF = 2;
    localparam int FB_ZF = 3;
    localparam int FB_SF = 4;
    localparam int FB_IF = 5;
    localparam int FB_DF = 6;
    localparam int FB_OF = 7;

    localparam logic [FLAG_W-1:0] ARITH_GRP =
        (FLAG_W'(1) << FB_CF) | (FLAG_W'(1) << FB_PF) | (FLAG_W'(1) << FB_AF) |
        (FLAG_W'(1) << FB_ZF) | (FLAG_W'(1) << FB_SF) | (FLAG_W'(1) << FB_OF);

    typedef enum logic [CLS_W-1:0] {
        OC_NOFLAG  = 5'd0,
        OC_INC     = 5'd1,
        OC_DEC     = 5'd2,
        OC_TEST    = 5'd3,
        OC_BTEST   = 5'd4,
        OC_BSCAN   = 5'd5,
        OC_CLRC    = 5'd6,
        OC_SETC    = 5'd7,
        OC_CPLC    = 5'd8,
        OC_CLRD    = 5'd9,
        OC_SETD    = 5'd10,
        OC_CLRI    = 5'd11,
        OC_SETI    = 5'd12,
        OC_MULU    = 5'd13,
        OC_MULS    = 5'd14,
        OC_SHIFT   = 5'd15,
        OC_ROTATE  = 5'd16,
        OC_AND     = 5'd17,
        OC_OR      = 5'd18,
        OC_XOR     = 5'd19,
        OC_ADD     = 5'd20,
        OC_ADDC    = 5'd21,
        OC_SUB     = 5'd22,
        OC_SUBB    = 5'd23,
        OC_CMP     = 5'd24,
        OC_NEG     = 5'd25,
        OC_LDFLAGS = 5'd26,
        OC_PUSHFL  = 5'd27,
        OC_BRANCH  = 5'd28,
        OC_SETCOND = 5'd29,
        OC_RSV30   = 5'd30,
        OC_RSV31   = 5'd31
    } op_class_e;

    typedef struct packed {
        op_class_e         cls;
        logic [FLAG_W-1:0] rd;
        logic [FLAG_W-1:0] wr;
    } dec_instr_t;

    typedef struct packed {
        op_class_e         cls;
        logic [FLAG_W-1:0] wr;
    } flag_write_t;

    typedef struct packed {
        logic              any_part;
        logic              ar_part;
        logic [FLAG_W-1:0] ar_mask;
    } flag_track_t;

    function automatic logic cls_is_partial(op_class_e c);
        return (c >= OC_INC) && (c <= OC_ROTATE);
    endfunction

    function automatic logic cls_is_full(op_class_e c);
        return (c >= OC_AND) && (c <= OC_NEG);
    endfunction

    function automatic logic cls_reads_all(op_class_e c);
        return (c == OC_LDFLAGS) || (c == OC_PUSHFL);
    endfunction

endpackage

// File: rtl/pfs_track.sv
module pfs_track
    import pfs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        upd_en,
    input  logic        clr_first,
    input  flag_write_t upd,
    output flag_track_t st
);

    flag_track_t base;
    flag_track_t nxt;
    logic [FLAG_W-1:0] ar_wr;

    assign ar_wr = upd.wr & ARITH_GRP;

    always_comb begin
        base = st;
        if (clr_first) begin
            base = '0;
        end
        nxt = base;
        if (cls_is_full(upd.cls)) begin
            nxt = '0;
        end else if (cls_is_partial(upd.cls)) begin
            nxt.any_part = 1'b1;
            if (ar_wr != '0) begin
                nxt.ar_part = 1'b1;
                nxt.ar_mask = ar_wr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (upd_en) begin
            st <= nxt;
        end
    end

endmodule

// File: rtl/pfs_hazard.sv
module pfs_hazard
    import pfs_pkg::*;
(
    input  flag_track_t       st,
    input  op_class_e         cls,
    input  logic [FLAG_W-1:0] rd,
    output logic              need_wait
);

    logic [FLAG_W-1:0] uncovered;
    logic [FLAG_W-1:0] miss_bits;

    genvar gi;
    generate
        for (gi = 0; gi < FLAG_W; gi++) begin : g_bit
            if (ARITH_GRP[gi]) begin : g_ar
                assign uncovered[gi] = st.ar_part & ~st.ar_mask[gi];
            end else begin : g_other
                assign uncovered[gi] = 1'b0;
            end
        end
    endgenerate

    assign miss_bits = rd & uncovered;

    always_comb begin
        if (cls_reads_all(cls)) begin
            need_wait = st.any_part;
        end else begin
            need_wait = |miss_bits;
        end
    end

endmodule

// File: rtl/pfs_penalty.sv
module pfs_penalty
    import pfs_pkg::*;
#(
    parameter int PENALTY = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  flag_write_t start_op,
    output logic        busy,
    output logic        release_now,
    output flag_write_t held
);

    localparam int CW = $clog2(PENALTY + 1);
    localparam logic [CW-1:0] LOAD = CW'(PENALTY);

    logic [CW-1:0] cnt;

    assign busy        = (cnt != '0);
    assign release_now = (cnt == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            held <= '0;
        end else if (start) begin
            cnt  <= LOAD;
            held <= start_op;
        end else if (busy) begin
            cnt  <= cnt - CW'(1);
        end
    end

endmodule

// File: rtl/pfs_stall_top.sv
module pfs_stall_top
    import pfs_pkg::*;
#(
    parameter int PENALTY = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [CLS_W-1:0]    in_cls,
    input  logic [FLAG_W-1:0]   in_rd,
    input  logic [FLAG_W-1:0]   in_wr,
    output logic                stall,
    output logic                iss_valid,
    output logic [CLS_W-1:0]    iss_cls,
    output logic                iss_waited
);

    dec_instr_t  cur;
    flag_write_t cur_w;
    flag_write_t held;
    flag_write_t upd_op;
    flag_track_t st;
    logic        busy;
    logic        rel;
    logic        need;
    logic        accept;
    logic        go;
    logic        hold_start;

    assign cur.cls  = op_class_e'(in_cls);
    assign cur.rd   = in_rd;
    assign cur.wr   = in_wr;
    assign cur_w.cls = cur.cls;
    assign cur_w.wr  = cur.wr;

    assign accept     = in_valid & ~busy;
    assign hold_start = accept & need;
    assign go         = accept & ~need;
    assign upd_op     = rel ? held : cur_w;

    pfs_hazard u_haz (
        .st        (st),
        .cls       (cur.cls),
        .rd        (cur.rd),
        .need_wait (need)
    );

    pfs_penalty #(.PENALTY(PENALTY)) u_pen (
        .clk         (clk),
        .rst         (rst),
        .start       (hold_start),
        .start_op    (cur_w),
        .busy        (busy),
        .release_now (rel),
        .held        (held)
    );

    pfs_track u_trk (
        .clk       (clk),
        .rst       (rst),
        .upd_en    (go | rel),
        .clr_first (rel),
        .upd       (upd_op),
        .st        (st)
    );

    assign stall = busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            iss_valid  <= 1'b0;
            iss_cls    <= '0;
            iss_waited <= 1'b0;
        end else begin
            iss_valid  <= go | rel;
            iss_waited <= rel;
            if (go | rel) begin
                iss_cls <= upd_op.cls;
            end
        end
    end

endmodule

// File: rtl/pfs_checker.sv
module pfs_checker #(
    parameter int PEN = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       stall,
    input logic       iss_valid,
    input logic [4:0] iss_cls,
    input logic       iss_waited
);

    localparam int RW = $clog2(PEN + 2);
    logic [RW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= '0;
        end else if (stall) begin
            run <= run + RW'(1);
        end else begin
            run <= '0;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!stall && !iss_valid));

    assert_stall_bound_R8: assert property (@(posedge clk) disable iff (rst)
        stall |-> (run < RW'(PEN)));

    assert_stall_exact_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(stall) |-> (run == RW'(PEN)));

    assert_no_issue_in_stall_R8: assert property (@(posedge clk) disable iff (rst)
        stall |-> !iss_valid);

    assert_release_issue_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(stall) |-> (iss_valid && iss_waited));

    assert_waited_valid_R9: assert property (@(posedge clk) disable iff (rst)
        iss_waited |-> iss_valid);

    assert_cls_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!iss_valid && !$past(rst)) |-> $stable(iss_cls));

endmodule

bind pfs_stall_top pfs_checker #(.PEN(PENALTY)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .stall      (stall),
    .iss_valid  (iss_valid),
    .iss_cls    (iss_cls),
    .iss_waited (iss_waited)
);

// File: tb/sim_pfs_stall_top.sv
`timescale 1ns/1ps
module sim_pfs_stall_top;

    localparam int PEN = 4;
    localparam int M_CF = 1, M_PF = 2, M_AF = 4, M_ZF = 8, M_SF = 16;
    localparam int M_IF = 32, M_DF = 64, M_OF = 128;
    localparam int ARM  = 8'h9F;

    logic       clk = 0;
    logic       rst = 1;
    logic       in_valid = 0;
    logic [4:0] in_cls = 0;
    logic [7:0] in_rd = 0;
    logic [7:0] in_wr = 0;
    logic       stall;
    logic       iss_valid;
    logic [4:0] iss_cls;
    logic       iss_waited;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;

    // reference model state
    int  m_wait = 0;
    bit  m_any = 0, m_ar = 0;
    int  m_mask = 0;
    int  h_cls = 0, h_wr = 0;
    bit  e_stall = 0, e_iss = 0, e_wt = 0;
    int  e_cls = 0;

    pfs_stall_top #(.PENALTY(PEN)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_cls(in_cls),
        .in_rd(in_rd), .in_wr(in_wr), .stall(stall), .iss_valid(iss_valid),
        .iss_cls(iss_cls), .iss_waited(iss_waited)
    );

    always #5 clk = ~clk;

    function automatic bit f_part(int c); return c >= 1 && c <= 16; endfunction
    function automatic bit f_full(int c); return c >= 17 && c <= 25; endfunction
    function automatic bit f_whole(int c); return c == 26 || c == 27; endfunction

    task automatic m_apply(int c, int w);
        if (f_full(c)) begin
            m_any = 0; m_ar = 0; m_mask = 0;
        end else if (f_part(c)) begin
            m_any = 1;
            if ((w & ARM) != 0) begin
                m_ar = 1; m_mask = w & ARM;
            end
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_wait = 0; m_any = 0; m_ar = 0; m_mask = 0;
            e_iss = 0; e_wt = 0; e_cls = 0; h_cls = 0; h_wr = 0;
        end else if (m_wait > 0) begin
            m_wait = m_wait - 1;
            e_wt = 0; e_iss = 0;
            if (m_wait == 0) begin
                m_any = 0; m_ar = 0; m_mask = 0;
                m_apply(h_cls, h_wr);
                e_iss = 1; e_wt = 1; e_cls = h_cls;
            end
        end else if (in_valid) begin
            bit hz;
            if (f_whole(int'(in_cls))) hz = m_any;
            else hz = m_ar && ((int'(in_rd) & ARM & ~m_mask) != 0);
            e_wt = 0;
            if (hz) begin
                m_wait = PEN; h_cls = int'(in_cls); h_wr = int'(in_wr); e_iss = 0;
            end else begin
                m_apply(int'(in_cls), int'(in_wr));
                e_iss = 1; e_cls = int'(in_cls);
            end
        end else begin
            e_iss = 0; e_wt = 0;
        end
        e_stall = (m_wait > 0);
    end

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // per-cycle comparison against the reference model
    always @(negedge clk) begin
        cycles++;
        if (!rst && !done) begin
            chk("R8 stall vs model", int'(stall), int'(e_stall));
            chk("R2 iss_valid vs model", int'(iss_valid), int'(e_iss));
            chk("R9 iss_waited vs model", int'(iss_waited), int'(e_wt));
            chk("R2 iss_cls vs model", int'(iss_cls), e_cls);
        end
    end

    // watchdog
    initial begin
        wait (cycles > 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // drive one instruction, check the stall decision, then drive filler through any stall
    task automatic step(int c, int r, int w, bit exp_st, string tag,
                        int fc = 0, int fr = 0, int fw = 0);
        @(negedge clk);
        in_valid = 1; in_cls = 5'(c); in_rd = 8'(r); in_wr = 8'(w);
        @(negedge clk);
        chk(tag, int'(stall), int'(exp_st));
        in_valid = (fc != 0); in_cls = 5'(fc); in_rd = 8'(fr); in_wr = 8'(fw);
        while (stall) @(negedge clk);
        in_valid = 0; in_cls = 0; in_rd = 0; in_wr = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 stall after reset", int'(stall), 0);
        chk("R1 no issue after reset", int'(iss_valid), 0);

        step(28, M_CF | M_ZF, 0, 0, "R1 first reader no stall");
        step(1, 0, 8'h9E, 0, "R11 inc itself no stall");
        step(28, M_CF | M_ZF, 0, 1, "R3 carry+zero branch after inc stalls");
        step(2, 0, 8'h9E, 0, "R11 dec no stall");
        step(28, M_CF, 0, 1, "R3 carry-only branch after dec stalls");
        step(1, 0, 8'h9E, 0, "R11 inc");
        step(28, M_ZF, 0, 0, "R4 zero-only branch after inc proceeds");
        step(15, 0, ARM, 0, "R11 shift");
        step(27, 0, 0, 1, "R6 push-flags after shift stalls");
        step(15, 0, ARM, 0, "R11 shift");
        step(18, 0, ARM, 0, "R5 or");
        step(27, 0, 0, 0, "R5 push-flags after shift,or proceeds");
        step(3, 0, 8'h9B, 0, "R11 test");
        step(26, 0, 0, 1, "R6 load-flags after test stalls");
        step(17, 0, 8'h9B, 0, "R5 and");
        step(26, 0, 0, 0, "R5 load-flags after and proceeds");
        step(3, 0, 8'h9B, 0, "R11 test");
        step(29, M_ZF, 0, 0, "R4 set-if-zero after test proceeds");
        step(6, 0, M_CF, 0, "R11 clear carry");
        step(29, M_ZF, 0, 1, "R3 set-if-zero after clear carry stalls");
        step(9, 0, M_DF, 0, "R11 clear direction");
        step(29, M_ZF, 0, 0, "R7 set-if-zero after clear direction proceeds");
        step(10, 0, M_DF, 0, "R11 set direction");
        step(27, 0, 0, 1, "R6 push-flags after set direction stalls");
        // partial producer driven during a stall must be ignored
        step(1, 0, 8'h9E, 0, "R11 inc");
        step(28, M_CF, 0, 1, "R8 stall with inc as filler", 1, 0, 8'h9E);
        step(28, M_CF, 0, 0, "R8 filler inc ignored, carry branch proceeds");
        // valid low with a partial payload
        @(negedge clk);
        in_valid = 0; in_cls = 5'd1; in_wr = 8'h9E;
        @(negedge clk);
        chk("R10 no issue with valid low", int'(iss_valid), 0);
        in_cls = 0; in_wr = 0;
        step(28, M_CF, 0, 0, "R10 state unchanged by invalid slot");
        // non-flag op between partial producer and reader
        step(1, 0, 8'h9E, 0, "R11 inc");
        step(0, 0, 0, 0, "R11 no-flag op never stalls");
        step(28, M_OF, 0, 0, "R11 branch on OF (written) proceeds");
        step(28, M_CF, 0, 1, "R11 state kept across non-flag ops");
        // held writer applies its own write after release
        step(1, 0, 8'h9E, 0, "R11 inc");
        step(8, M_CF, M_CF, 1, "R3 complement carry after inc stalls");
        step(29, M_ZF, 0, 1, "R9 held cmc write applied after release");
        step(29, M_IF | M_DF, 0, 0, "R7 reader of only non-arith flags proceeds");

        // random stream compared against the reference model each cycle
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            in_valid = ($urandom_range(0, 3) != 0);
            in_cls   = 5'($urandom_range(0, 29));
            case ($urandom_range(0, 3))
                0: in_rd = 0;
                1: in_rd = 8'(M_ZF);
                2: in_rd = 8'(M_CF | M_ZF);
                default: in_rd = 8'($urandom_range(0, 255));
            endcase
            case ($urandom_range(0, 3))
                0: in_wr = 8'h9E;
                1: in_wr = 8'(M_CF);
                2: in_wr = 8'(M_DF | M_IF);
                default: in_wr = 8'($urandom_range(0, 255));
            endcase
        end
        @(negedge clk);
        in_valid = 0;
        repeat (8) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule